// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns one 32-bit linear address into a physical page frame. It handles one access at a time, and each access carries a write flag and a user flag. When a request is accepted, the block samples the paging-enable and supervisor-write-protect control bits, the table root base, the large-page enable and the A20 address mask. It then reads the directory entry and, for small pages, the table entry through a single-word memory port. It sets the accessed and dirty bits in memory where the access calls for them. It returns either a translation or a fault.

A translation holds the virtual page number, the physical page number and a write-permission flag. A fault holds a three-bit error code. Write permission is granted only for pages that are already dirty. A read of a clean page therefore yields a read-only translation, and the first later write re-walks and marks the page dirty. Large 4 MB pages are walked in one level, but the walker still returns a single 4 KB translation inside them. The page cache and the raising of the exception belong to the surrounding logic.

Top module: `pgwalk_top`

## Requirements
- R1: With paging disabled, the block makes no memory access and does not fault. It returns write permission, and the physical page equals the linear page ANDed with bits 31:12 of the A20 mask.
- R2: The first read goes to ((root & ~0xFFF) + ((lin >> 20) & ~3)) & a20_mask.
- R3: The table read goes to ((directory entry & ~0xFFF) + ((lin >> 10) & 0xFFC)) & a20_mask.
- R4: Entry bit 0 is the present bit. A missing entry at either level faults with error bit 0 = 0. A protection fault has error bit 0 = 1. Error bit 1 is the write flag and error bit 2 is the user flag. A completed translation reports error code 0.
- R5: A one-level large-page walk happens only when directory bit 7 and the large-page enable are both 1. Its physical page is (directory bits 31:22 with bits 21:12 zero, ANDed with the mask) OR linear bits 21:12. With either of the two bits clear, the walker does a normal two-level walk.
- R6: Bit 2 is the user-allowed bit and bit 1 is the writable bit. On small pages, both rights are the AND of the two entries. A user access faults if the user bit is 0, and a user write also faults if the writable bit is 0. A supervisor write faults on a clear writable bit only when write protect is 1.
- R7: The final entry gets bit 5 (accessed) set, and bit 6 (dirty) also set on a write. It is written back only if its value changes. On a small-page walk, the directory entry gets its accessed bit set, and is written, only if that bit was 0. A fault on the final entry causes no write to it.
- R8: Write permission is 1 only if the updated final entry is dirty, and only if one of the following holds: the access is a user access and the writable bit is 1; or the access is a supervisor access and either the writable bit is 1 or write protect is 0. Write permission is 0 on a fault.
- R9: The virtual page is linear bits 31:12. For a small page, the physical page is table bits 31:12 ANDed with mask bits 31:12.
- R10: A request is taken only while ready is high, and a request arriving while busy is dropped. The done output is high for exactly one cycle. A memory request is held stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| cr0_pg | input | 1 | Paging enabled |
| cr0_wp | input | 1 | Supervisor write protect |
| cr3 | input | 32 | Table root base (low 12 bits ignored) |
| cr4_pse | input | 1 | Large-page enable |
| a20_mask | input | 32 | Physical address mask |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | Result valid (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| err_code | output | 3 | {user, write, protection} |
| vpage | output | 20 | Virtual page number |
| ppage | output | 20 | Physical page number |
| wr_ok | output | 1 | Write permitted by translation |

## Verification
The bench builds the walker with its default 32-bit address width. That is the only width the entry bit layout supports, so it gives the bench the full table index range and both A20 mask settings. Random roots, addresses, entries and control bits reach every combination of present, user, writable, accessed, dirty and large-page bits. Directed cases cover the state transitions that random entries rarely reach: a clean read followed by a write, a repeated access that needs no writeback, and a request that arrives while the walker is busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 10;
  localparam int ENT_P    = 0;
  localparam int ENT_RW   = 1;
  localparam int ENT_US   = 2;
  localparam int ENT_A    = 5;
  localparam int ENT_D    = 6;
  localparam int ENT_PS   = 7;

  typedef enum logic [2:0] {
    W_IDLE,
    W_RD_DIR,
    W_WB_DIR,
    W_RD_TBL,
    W_WB_TBL,
    W_DONE
  } walk_st_e;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-PG_SHIFT-1:0] root_frame,
  input  logic [ADDR_W-PG_SHIFT-1:0] dir_frame,
  input  logic [ADDR_W-1:0]          lin,
  input  logic [ADDR_W-1:0]          a20,
  output logic [ADDR_W-1:0]          dir_addr,
  output logic [ADDR_W-1:0]          tbl_addr
);
  localparam int DIR_SH = PG_SHIFT + IDX_W - 2;
  localparam int TBL_SH = PG_SHIFT - 2;
  localparam logic [ADDR_W-1:0] TBL_MSK = ADDR_W'(((1 << IDX_W) - 1) << 2);

  logic [ADDR_W-1:0] dir_off, tbl_off;

  always_comb begin
    dir_off  = (lin >> DIR_SH) & ~ADDR_W'(3);
    tbl_off  = (lin >> TBL_SH) & TBL_MSK;
    dir_addr = ({root_frame, {PG_SHIFT{1'b0}}} + dir_off) & a20;
    tbl_addr = ({dir_frame, {PG_SHIFT{1'b0}}} + tbl_off) & a20;
  end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pde,
  input  logic [ADDR_W-1:0] pte,
  input  logic              big,
  input  logic              wr,
  input  logic              usr,
  input  logic              wp,
  output logic              prot_fault,
  output logic [ADDR_W-1:0] upd_entry,
  output logic              upd_needed,
  output logic              wr_grant
);
  logic              r_rw, r_us;
  logic [ADDR_W-1:0] fin;

  always_comb begin
    fin  = big ? pde : pte;
    r_rw = big ? pde[ENT_RW] : (pde[ENT_RW] & pte[ENT_RW]);
    r_us = big ? pde[ENT_US] : (pde[ENT_US] & pte[ENT_US]);
    if (usr)
      prot_fault = !r_us || (wr && !r_rw);
    else
      prot_fault = wr && wp && !r_rw;
    upd_entry  = fin | (ADDR_W'(1) << ENT_A) | (wr ? (ADDR_W'(1) << ENT_D) : '0);
    upd_needed = (upd_entry != fin);
    wr_grant   = upd_entry[ENT_D] && (usr ? r_rw : (r_rw || !wp));
  end
endmodule

// File: rtl/pgw_frame.sv
module pgw_frame
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-PG_SHIFT-1:0] ent_frame,
  input  logic [IDX_W-1:0]           lin_mid,
  input  logic [ADDR_W-PG_SHIFT-1:0] a20_frame,
  input  logic                       big,
  output logic [ADDR_W-PG_SHIFT-1:0] ppage
);
  localparam int VPN_W = ADDR_W - PG_SHIFT;

  always_comb begin
    if (big)
      ppage = ({ent_frame[VPN_W-1:IDX_W], {IDX_W{1'b0}}} & a20_frame)
              | {{(VPN_W-IDX_W){1'b0}}, lin_mid};
    else
      ppage = ent_frame & a20_frame;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_lin,
  input  logic                       req_write,
  input  logic                       req_user,
  input  logic                       cr0_pg,
  input  logic                       cr0_wp,
  input  logic [ADDR_W-1:0]          cr3,
  input  logic                       cr4_pse,
  input  logic [ADDR_W-1:0]          a20_mask,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [ADDR_W-1:0]          mem_wdata,
  input  logic [ADDR_W-1:0]          mem_rdata,
  input  logic                       mem_ack,
  output logic                       done,
  output logic                       fault,
  output logic [2:0]                 err_code,
  output logic [ADDR_W-PG_SHIFT-1:0] vpage,
  output logic [ADDR_W-PG_SHIFT-1:0] ppage,
  output logic                       wr_ok
);
  localparam int VPN_W = ADDR_W - PG_SHIFT;
  localparam logic [ADDR_W-1:0] ACC_M = ADDR_W'(1) << ENT_A;

  walk_st_e          st;
  logic [ADDR_W-1:0] lin_q, a20_q, pde_q, wb_q;
  logic [VPN_W-1:0]  root_q;
  logic              wr_q, usr_q, wp_q, pse_q, big_q;

  logic              fault_q, wrok_q;
  logic [2:0]        err_q;
  logic [VPN_W-1:0]  vpage_q, ppage_q;

  logic [ADDR_W-1:0] dir_addr, tbl_addr;
  logic [ADDR_W-1:0] perm_pde, upd_entry;
  logic              perm_big, prot_fault, upd_needed, wr_grant;
  logic [VPN_W-1:0]  frame_pg;

  pgw_addr #(.ADDR_W(ADDR_W)) u_addr (
    .root_frame (root_q),
    .dir_frame  (pde_q[ADDR_W-1:PG_SHIFT]),
    .lin        (lin_q),
    .a20        (a20_q),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr)
  );

  assign perm_big = (st == W_RD_DIR);
  assign perm_pde = perm_big ? mem_rdata : pde_q;

  pgw_perm #(.ADDR_W(ADDR_W)) u_perm (
    .pde        (perm_pde),
    .pte        (mem_rdata),
    .big        (perm_big),
    .wr         (wr_q),
    .usr        (usr_q),
    .wp         (wp_q),
    .prot_fault (prot_fault),
    .upd_entry  (upd_entry),
    .upd_needed (upd_needed),
    .wr_grant   (wr_grant)
  );

  pgw_frame #(.ADDR_W(ADDR_W)) u_frame (
    .ent_frame (upd_entry[ADDR_W-1:PG_SHIFT]),
    .lin_mid   (lin_q[PG_SHIFT+IDX_W-1:PG_SHIFT]),
    .a20_frame (a20_q[ADDR_W-1:PG_SHIFT]),
    .big       (perm_big),
    .ppage     (frame_pg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      lin_q   <= '0;
      a20_q   <= '0;
      pde_q   <= '0;
      wb_q    <= '0;
      root_q  <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      wp_q    <= 1'b0;
      pse_q   <= 1'b0;
      big_q   <= 1'b0;
      fault_q <= 1'b0;
      wrok_q  <= 1'b0;
      err_q   <= '0;
      vpage_q <= '0;
      ppage_q <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (req_valid) begin
            lin_q   <= req_lin;
            a20_q   <= a20_mask;
            root_q  <= cr3[ADDR_W-1:PG_SHIFT];
            wr_q    <= req_write;
            usr_q   <= req_user;
            wp_q    <= cr0_wp;
            pse_q   <= cr4_pse;
            big_q   <= 1'b0;
            fault_q <= 1'b0;
            err_q   <= '0;
            vpage_q <= req_lin[ADDR_W-1:PG_SHIFT];
            if (cr0_pg) begin
              wrok_q  <= 1'b0;
              ppage_q <= '0;
              st      <= W_RD_DIR;
            end else begin
              wrok_q  <= 1'b1;
              ppage_q <= req_lin[ADDR_W-1:PG_SHIFT] & a20_mask[ADDR_W-1:PG_SHIFT];
              st      <= W_DONE;
            end
          end
        end
        W_RD_DIR: begin
          if (mem_ack) begin
            if (!mem_rdata[ENT_P]) begin
              fault_q <= 1'b1;
              err_q   <= {usr_q, wr_q, 1'b0};
              st      <= W_DONE;
            end else if (mem_rdata[ENT_PS] && pse_q) begin
              big_q <= 1'b1;
              if (prot_fault) begin
                fault_q <= 1'b1;
                err_q   <= {usr_q, wr_q, 1'b1};
                st      <= W_DONE;
              end else begin
                ppage_q <= frame_pg;
                wrok_q  <= wr_grant;
                wb_q    <= upd_entry;
                st      <= upd_needed ? W_WB_DIR : W_DONE;
              end
            end else begin
              pde_q <= mem_rdata | ACC_M;
              wb_q  <= mem_rdata | ACC_M;
              st    <= mem_rdata[ENT_A] ? W_RD_TBL : W_WB_DIR;
            end
          end
        end
        W_WB_DIR: begin
          if (mem_ack) st <= big_q ? W_DONE : W_RD_TBL;
        end
        W_RD_TBL: begin
          if (mem_ack) begin
            if (!mem_rdata[ENT_P]) begin
              fault_q <= 1'b1;
              err_q   <= {usr_q, wr_q, 1'b0};
              st      <= W_DONE;
            end else if (prot_fault) begin
              fault_q <= 1'b1;
              err_q   <= {usr_q, wr_q, 1'b1};
              st      <= W_DONE;
            end else begin
              ppage_q <= frame_pg;
              wrok_q  <= wr_grant;
              wb_q    <= upd_entry;
              st      <= upd_needed ? W_WB_TBL : W_DONE;
            end
          end
        end
        W_WB_TBL: begin
          if (mem_ack) st <= W_DONE;
        end
        W_DONE:  st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign req_ready = (st == W_IDLE);
  assign done      = (st == W_DONE);
  assign mem_req   = (st == W_RD_DIR) || (st == W_WB_DIR) ||
                     (st == W_RD_TBL) || (st == W_WB_TBL);
  assign mem_we    = (st == W_WB_DIR) || (st == W_WB_TBL);
  assign mem_addr  = ((st == W_RD_TBL) || (st == W_WB_TBL)) ? tbl_addr : dir_addr;
  assign mem_wdata = wb_q;
  assign fault     = fault_q;
  assign err_code  = err_q;
  assign vpage     = vpage_q;
  assign ppage     = ppage_q;
  assign wr_ok     = wrok_q;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cr0_pg,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              acc_bit,
  input logic              done,
  input logic              fault,
  input logic [2:0]        err_code,
  input logic              wr_ok
);
  logic pg_l;

  always_ff @(posedge clk) begin
    if (rst) pg_l <= 1'b0;
    else if (req_valid && req_ready) pg_l <= cr0_pg;
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);
  assert_wb_accessed_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> acc_bit);
  assert_fault_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> !wr_ok);
  assert_ok_err_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (err_code == 3'b000));
  assert_nopg_no_mem_R1: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !pg_l) |-> !mem_req);
endmodule

bind pgwalk_top pgw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cr0_pg    (cr0_pg),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .acc_bit   (mem_wdata[5]),
  .done      (done),
  .fault     (fault),
  .err_code  (err_code),
  .wr_ok     (wr_ok)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        cr0_pg = 1'b0, cr0_wp = 1'b0, cr4_pse = 1'b0;
  logic [31:0] req_lin = '0, cr3 = '0, a20_mask = 32'hFFFF_FFFF;
  logic        req_ready, mem_req, mem_we, done, fault, wr_ok;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  err_code;
  logic [19:0] vpage, ppage;

  always #10 clk = ~clk;

  pgwalk_top #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
    .cr0_pg(cr0_pg), .cr0_wp(cr0_wp), .cr3(cr3), .cr4_pse(cr4_pse),
    .a20_mask(a20_mask), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done(done), .fault(fault), .err_code(err_code),
    .vpage(vpage), .ppage(ppage), .wr_ok(wr_ok)
  );

  logic [31:0] dut_mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  int          n_rd, n_wr;
  logic [31:0] rd_log [2];
  int          tests = 0, fails = 0;
  bit          finished = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        dut_mem[mem_addr] = mem_wdata;
        n_wr = n_wr + 1;
      end else begin
        mem_rdata <= dut_mem.exists(mem_addr) ? dut_mem[mem_addr] : 32'h0;
        if (n_rd < 2) rd_log[n_rd] = mem_addr;
        n_rd = n_rd + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] dut_rd(input logic [31:0] a);
    return dut_mem.exists(a) ? dut_mem[a] : 32'h0;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    dut_mem[a] = d;
    ref_mem[a] = d;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic        e_fault, e_wok;
  logic [2:0]  e_err;
  logic [19:0] e_vp, e_pp;
  int          e_rd, e_wr;
  logic [31:0] e_pa, e_ta;

  task automatic ref_walk(input logic [31:0] lin, input logic w, input logic u,
                          input logic pg, input logic wp, input logic [31:0] root,
                          input logic pse, input logic [31:0] msk);
    logic [31:0] pde, pte, rights, ent, nent;
    logic big;
    e_vp = lin[31:12]; e_pp = '0; e_fault = 0; e_err = '0; e_wok = 0;
    e_rd = 0; e_wr = 0; e_pa = '0; e_ta = '0;
    if (!pg) begin
      e_pp = lin[31:12] & msk[31:12];
      e_wok = 1;
      return;
    end
    e_pa = ((root & ~32'hFFF) + ((lin >> 20) & ~32'h3)) & msk;
    pde = ref_rd(e_pa); e_rd++;
    if (!pde[0]) begin e_fault = 1; e_err = {u, w, 1'b0}; return; end
    big = pde[7] && pse;
    if (big) begin
      rights = pde; ent = pde;
    end else begin
      if (!pde[5]) begin pde = pde | 32'h20; ref_mem[e_pa] = pde; e_wr++; end
      e_ta = ((pde & ~32'hFFF) + ((lin >> 10) & 32'hFFC)) & msk;
      pte = ref_rd(e_ta); e_rd++;
      if (!pte[0]) begin e_fault = 1; e_err = {u, w, 1'b0}; return; end
      rights = pde & pte; ent = pte;
    end
    if ((u && (!rights[2] || (w && !rights[1]))) || (!u && w && wp && !rights[1])) begin
      e_fault = 1; e_err = {u, w, 1'b1}; return;
    end
    nent = ent | 32'h20 | (w ? 32'h40 : 32'h0);
    if (nent != ent) begin
      ref_mem[big ? e_pa : e_ta] = nent; e_wr++;
    end
    e_wok = nent[6] && (u ? rights[1] : (rights[1] || !wp));
    if (big) e_pp = ({nent[31:22], 10'b0} & msk[31:12]) | {10'b0, lin[21:12]};
    else     e_pp = nent[31:12] & msk[31:12];
  endtask

  task automatic run_case(input logic [31:0] lin, input logic w, input logic u,
                          input logic pg, input logic wp, input logic [31:0] root,
                          input logic pse, input logic [31:0] msk, input bit poke);
    int k;
    ref_walk(lin, w, u, pg, wp, root, pse, msk);
    n_rd = 0; n_wr = 0; rd_log[0] = '0; rd_log[1] = '0;
    req_lin = lin; req_write = w; req_user = u; cr0_pg = pg; cr0_wp = wp;
    cr3 = root; cr4_pse = pse; a20_mask = msk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      check("R10 busy not ready", {31'b0, req_ready}, 32'h0);
      req_lin = ~lin; req_write = ~w; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    k = 0;
    while (!done && k < 200) begin @(negedge clk); k++; end
    if (!done) begin
      fails++; tests++;
      $display("FAIL R10 timeout: actual no done expected done");
      return;
    end
    check("R4 fault", {31'b0, fault}, {31'b0, e_fault});
    check("R4 err code", {29'b0, err_code}, {29'b0, e_err});
    check("R9 vpage", {12'b0, vpage}, {12'b0, e_vp});
    if (!e_fault) begin
      check("R9 ppage", {12'b0, ppage}, {12'b0, e_pp});
      check("R8 wr_ok", {31'b0, wr_ok}, {31'b0, e_wok});
    end
    check("R7 read count", n_rd, e_rd);
    check("R7 write count", n_wr, e_wr);
    if (e_rd >= 1) check("R2 dir address", rd_log[0], e_pa);
    if (e_rd >= 2) check("R3 tbl address", rd_log[1], e_ta);
    if (pg) begin
      check("R7 dir entry mem", dut_rd(e_pa), ref_rd(e_pa));
      if (e_rd >= 2) check("R7 tbl entry mem", dut_rd(e_ta), ref_rd(e_ta));
    end
    @(negedge clk);
    check("R10 one-cycle done", {31'b0, done}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset ready", {31'b0, req_ready}, 32'h1);
    check("R10 reset done", {31'b0, done}, 32'h0);
    check("R10 reset mem_req", {31'b0, mem_req}, 32'h0);

    // R1: no paging, A20 clears bit 20
    run_case(32'h1234_5678, 1, 1, 0, 1, 32'h0, 0, 32'hFFEF_FFFF, 0);
    check("R1 identity page", {12'b0, ppage}, 32'h12245);
    check("R1 no memory access", n_rd + n_wr, 0);

    // R4: directory entry not present, user write
    put(32'h1004, 32'h0);
    run_case(32'h0040_3000, 1, 1, 1, 0, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R4 not-present code", {29'b0, err_code}, 32'h6);

    // R7/R8: clean supervisor read sets both accessed bits, no write grant
    put(32'h1008, 32'h0000_2003);
    put(32'h2014, 32'h0003_4003);
    run_case(32'h0080_5000, 0, 0, 1, 1, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R7 two writebacks", n_wr, 2);
    check("R8 clean read no write", {31'b0, wr_ok}, 32'h0);
    check("R9 small page frame", {12'b0, ppage}, 32'h00034);
    // write marks dirty, then repeated read needs no writeback
    run_case(32'h0080_5000, 1, 0, 1, 1, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R8 dirty write grant", {31'b0, wr_ok}, 32'h1);
    check("R7 dirty bit set", dut_rd(32'h2014), 32'h0003_4063);
    run_case(32'h0080_5000, 0, 0, 1, 1, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R7 no change no write", n_wr, 0);

    // R6: user access with directory user bit clear
    run_case(32'h0080_5000, 0, 1, 1, 0, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R6 user bit fault", {29'b0, err_code}, 32'h5);

    // R6: supervisor write to read-only page, with and without write protect
    put(32'h2018, 32'h0003_5061);
    run_case(32'h0080_6000, 1, 0, 1, 0, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R6 sup write wp off", {31'b0, fault}, 32'h0);
    run_case(32'h0080_6000, 1, 0, 1, 1, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R6 sup write wp on", {29'b0, err_code}, 32'h3);

    // R5: large page enabled and disabled
    put(32'h10C0, 32'h0840_00E7);
    run_case(32'h0C12_3000, 0, 1, 1, 1, 32'h1000, 1, 32'hFFFF_FFFF, 0);
    check("R5 large frame", {12'b0, ppage}, 32'h08523);
    check("R5 one level", n_rd, 1);
    run_case(32'h0C12_3000, 0, 1, 1, 1, 32'h1000, 0, 32'hFFFF_FFFF, 0);
    check("R5 pse off two levels", n_rd, 2);

    // R2: A20 mask applied to directory address
    run_case(32'h0080_5000, 0, 0, 1, 0, 32'h0010_1000, 0, 32'hFFEF_FFFF, 0);
    check("R2 masked dir addr", rd_log[0], 32'h1008);

    // R10: request while busy is dropped
    run_case(32'h0080_5000, 0, 0, 1, 0, 32'h1000, 0, 32'hFFFF_FFFF, 1);
    repeat (3) @(negedge clk);
    check("R10 busy request dropped", {30'b0, req_ready, mem_req}, 32'h2);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] root, lin, pde, pte, msk, pa, ta;
      logic w, u, pg, wp, pse;
      root = $urandom & 32'h0003_F000;
      lin  = $urandom;
      w    = $urandom % 2;
      u    = $urandom % 2;
      pg   = ($urandom % 8) != 0;
      wp   = $urandom % 2;
      pse  = $urandom % 2;
      msk  = (($urandom % 4) == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      pde  = ($urandom & 32'h0FFF_F0FF);
      if (($urandom % 8) != 0) pde[0] = 1'b1;
      if (($urandom % 2) != 0) pde[2:1] = 2'b11;
      pte  = $urandom;
      if (($urandom % 8) != 0) pte[0] = 1'b1;
      pa = ((root & ~32'hFFF) + ((lin >> 20) & ~32'h3)) & msk;
      put(pa, pde);
      ta = ((pde & ~32'hFFF) + ((lin >> 10) & 32'hFFC)) & msk;
      if (ta != pa) put(ta, pte);
      run_case(lin, w, u, pg, wp, root, pse, msk, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule